// File: doc/BRIEF.md
# Dual-Mode Serial Error Flag Unit

This block holds the error detection and sticky status flags for a serial channel that runs either as an asynchronous receiver/transmitter or as a clocked synchronous shift interface. In asynchronous mode it frames incoming characters using a 16x oversampling tick. It checks the optional parity bit and the first stop bit, and it notices when a finished character would overwrite one that has not yet been read. In synchronous mode it shifts out bytes written into a one-deep transmit buffer, either on edges of an external shift clock or on a clock it generates itself. It flags a transmit under-run when the shift register runs dry.

One sticky flag has two meanings. In asynchronous mode it reports a parity error, and in synchronous mode it reports a transmit under-run. When the generated clock is in use, this flag also freezes that clock. All three flags stay set until software pulses the status-read strobe. The framing flag is held clear whenever the channel is in synchronous mode.

Top module: `sef_err_unit`

## Requirements
- R1: In asynchronous mode with parity enabled, a received parity bit that differs from the expected value sets `pe_ur_flag`. With even parity (`par_odd`=0) the expected bit is the XOR of the data bits. With odd parity it is that XOR inverted.
- R2: With `par_en`=0, the frame carries no parity bit and `pe_ur_flag` never sets in asynchronous mode.
- R3: The stop bit is sampled at oversample count 8 of its bit period. A sampled 0 sets `frame_flag`.
- R4: With `two_stop`=1, only the first stop bit is checked. A 0 in the second stop bit sets no flag.
- R5: `frame_flag` reads 0 from the cycle after the channel enters synchronous mode, for as long as it stays there, even if the flag was set before.
- R6: When a character completes while the previous one is still unread (no `rx_rd` since it arrived), `ovr_flag` sets and `rx_data` keeps the older byte.
- R7: In external-clock synchronous mode with `dbuf_en`=1, a rising edge of `sclk_in` that arrives after a byte has fully shifted out, with no byte waiting in the buffer, sets `pe_ur_flag`.
- R8: With `dbuf_en`=0, no under-run is ever flagged in synchronous mode.
- R9: In internal-clock mode the block drives `sclk_out` low then high once per data bit, 8 rising edges per byte. It idles high, and it is held high in asynchronous mode. With `dbuf_en`=1, `pe_ur_flag` sets once all buffered bytes are out.
- R10: While `pe_ur_flag` is set in internal-clock mode, `sclk_out` stays high even if new data is written. Shifting resumes after a status read.
- R11: Every flag is sticky until a `stat_rd` pulse. A new error event in the same cycle as the read leaves the flag set.
- R12: Bits travel least significant first. Received bits are assembled into `rx_data`, and `txd` presents each transmit bit before the shift-clock rising edge.
- R13: After reset all flags are 0, `rx_data` is 0, and `txd` and `sclk_out` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_uart | input | 1 | 1: asynchronous mode, 0: synchronous shift mode |
| clk_int | input | 1 | Synchronous mode: 1 generates the shift clock, 0 uses `sclk_in` |
| dbuf_en | input | 1 | Transmit double buffering enable (gates under-run detection) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | Frame carries two stop bits |
| os_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial receive line |
| rx_rd | input | 1 | Received byte read strobe |
| rx_data | output | DATA_BITS | Last accepted received byte |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| shift_tick | input | 1 | Half-period enable for the generated shift clock |
| sclk_in | input | 1 | External shift clock |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DATA_BITS | Transmit byte |
| txd | output | 1 | Serial transmit line |
| sclk_out | output | 1 | Generated shift clock |
| pe_ur_flag | output | 1 | Parity error (asynchronous) or under-run (synchronous) |
| frame_flag | output | 1 | Framing error |
| ovr_flag | output | 1 | Receive overrun |

## Verification
If the receive framing state has drifted or is corrupted, the fault shows within one character time. It appears as a wrong `rx_data` byte or a parity or framing flag that does not match the injected fault, so every frame in the sweep is checked for all three. A transmit counter or buffer-full bit in the wrong state shows as a byte that differs once the bits on `txd` are reassembled. It can also show as an under-run flag one edge too early or too late, or as a wrong count of generated clock edges, all visible within a byte of the write. A broken clear or halt path shows on the next status read, or as a clock that keeps toggling while the flag is set.

// File: rtl/sef_pkg.sv
package sef_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_TAIL,
    RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic pe_ur;
    logic frame;
    logic ovr;
  } err_evt_t;

endpackage

// File: rtl/sef_sync.sv
module sef_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sef_uart_rx.sv
module sef_uart_rx
  import sef_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OS_RATE   = 16,
  parameter int SAMPLE_AT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 os_tick,
  input  logic                 rxd_s,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 two_stop,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 par_bad,
  output logic                 stop_bad
);
  localparam int CW = $clog2(OS_RATE);
  localparam int BW = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] SMP  = CW'(SAMPLE_AT);
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);
  localparam logic [BW-1:0] BLST = BW'(DATA_BITS - 1);

  rx_state_e            st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 pbit_q, pbit_d;
  logic                 at_smp, at_last;

  assign at_smp  = os_tick && (cnt_q == SMP);
  assign at_last = os_tick && (cnt_q == LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    pbit_d = pbit_q;
    if (!enable) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (os_tick) begin
      if (st_q != RX_IDLE) cnt_d = cnt_q + 1'b1;
      unique case (st_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            st_d  = RX_START;
            cnt_d = CW'(1);
          end
        end
        RX_START: begin
          if (at_smp && rxd_s) begin
            st_d  = RX_IDLE;
            cnt_d = '0;
          end else if (at_last) begin
            st_d  = RX_DATA;
            cnt_d = '0;
            bit_d = '0;
          end
        end
        RX_DATA: begin
          if (at_smp) sh_d = {rxd_s, sh_q[DATA_BITS-1:1]};
          if (at_last) begin
            cnt_d = '0;
            if (bit_q == BLST) st_d = par_en ? RX_PAR : RX_STOP;
            else               bit_d = bit_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_smp) pbit_d = rxd_s;
          if (at_last) begin
            cnt_d = '0;
            st_d  = RX_STOP;
          end
        end
        RX_STOP: begin
          if (at_smp) st_d = RX_TAIL;
        end
        RX_TAIL: begin
          if (at_last) begin
            cnt_d = '0;
            st_d  = two_stop ? RX_STOP2 : RX_IDLE;
          end
        end
        RX_STOP2: begin
          if (at_last) begin
            cnt_d = '0;
            st_d  = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      pbit_q <= pbit_d;
    end
  end

  assign done     = enable && at_smp && (st_q == RX_STOP);
  assign data     = sh_q;
  assign par_bad  = par_en && (pbit_q != ((^sh_q) ^ par_odd));
  assign stop_bad = !rxd_s;
endmodule

// File: rtl/sef_sio_tx.sv
module sef_sio_tx #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 clk_int,
  input  logic                 dbuf_en,
  input  logic                 halt,
  input  logic                 shift_tick,
  input  logic                 sclk_s,
  input  logic                 tx_wr,
  input  logic [DATA_BITS-1:0] tx_wdata,
  output logic                 txd,
  output logic                 sclk_out,
  output logic                 underrun
);
  localparam int BW = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [BW-1:0] BLST = BW'(DATA_BITS - 1);

  logic [DATA_BITS-1:0] buf_q, buf_d, sh_q, sh_d;
  logic                 bfull_q, bfull_d;
  logic                 busy_q, busy_d;
  logic                 sent_q, sent_d;
  logic                 gen_q, gen_d;
  logic                 prev_q;
  logic [BW-1:0]        cnt_q, cnt_d;
  logic                 run, ext_edge, int_edge, shift_ev;

  assign run      = busy_q && !halt;
  assign ext_edge = sclk_s && !prev_q;
  assign int_edge = shift_tick && run && !gen_q;
  assign shift_ev = clk_int ? int_edge : ext_edge;

  always_comb begin
    buf_d    = buf_q;
    bfull_d  = bfull_q;
    sh_d     = sh_q;
    busy_d   = busy_q;
    sent_d   = sent_q;
    gen_d    = gen_q;
    cnt_d    = cnt_q;
    underrun = 1'b0;
    if (!enable) begin
      bfull_d = 1'b0;
      busy_d  = 1'b0;
      sent_d  = 1'b0;
      gen_d   = 1'b1;
      cnt_d   = '0;
    end else begin
      if (!clk_int || !run) gen_d = 1'b1;
      else if (shift_tick)  gen_d = ~gen_q;

      if (busy_q) begin
        if (shift_ev) begin
          sh_d = sh_q >> 1;
          if (cnt_q == BLST) begin
            cnt_d = '0;
            if (bfull_q) begin
              sh_d    = buf_q;
              bfull_d = 1'b0;
            end else begin
              busy_d   = 1'b0;
              sent_d   = 1'b1;
              underrun = clk_int && dbuf_en;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end else if (bfull_q) begin
        sh_d    = buf_q;
        bfull_d = 1'b0;
        busy_d  = 1'b1;
        sent_d  = 1'b0;
        cnt_d   = '0;
      end else if (ext_edge && !clk_int && sent_q && dbuf_en) begin
        underrun = 1'b1;
      end

      if (tx_wr) begin
        buf_d   = tx_wdata;
        bfull_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      bfull_q <= 1'b0;
      sh_q    <= '0;
      busy_q  <= 1'b0;
      sent_q  <= 1'b0;
      gen_q   <= 1'b1;
      prev_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      buf_q   <= buf_d;
      bfull_q <= bfull_d;
      sh_q    <= sh_d;
      busy_q  <= busy_d;
      sent_q  <= sent_d;
      gen_q   <= gen_d;
      prev_q  <= sclk_s;
      cnt_q   <= cnt_d;
    end
  end

  assign txd      = busy_q ? sh_q[0] : 1'b1;
  assign sclk_out = (enable && clk_int) ? gen_q : 1'b1;
endmodule

// File: rtl/sef_flags.sv
module sef_flags
  import sef_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_evt_t set,
  input  logic     rd_clr,
  input  logic     frame_hold,
  output err_evt_t flags
);
  err_evt_t q, d;

  always_comb begin
    d.pe_ur = set.pe_ur | (q.pe_ur & ~rd_clr);
    d.ovr   = set.ovr   | (q.ovr   & ~rd_clr);
    d.frame = frame_hold ? 1'b0 : (set.frame | (q.frame & ~rd_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign flags = q;
endmodule

// File: rtl/sef_err_unit.sv
module sef_err_unit
  import sef_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OS_RATE     = 16,
  parameter int SAMPLE_AT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_uart,
  input  logic                 clk_int,
  input  logic                 dbuf_en,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 two_stop,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic                 rx_rd,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 stat_rd,
  input  logic                 shift_tick,
  input  logic                 sclk_in,
  input  logic                 tx_wr,
  input  logic [DATA_BITS-1:0] tx_wdata,
  output logic                 txd,
  output logic                 sclk_out,
  output logic                 pe_ur_flag,
  output logic                 frame_flag,
  output logic                 ovr_flag
);
  logic                 rst_ns, rxd_s, sclk_s;
  logic                 rx_done, rx_par_bad, rx_stop_bad, tx_unr, halt;
  logic [DATA_BITS-1:0] rx_word;
  logic [DATA_BITS-1:0] rxd_q, rxd_d;
  logic                 full_q, full_d;
  err_evt_t             evt, flags;

  sef_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns));
  sef_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_ns), .d(rxd), .q(rxd_s));
  sef_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_ns), .d(sclk_in), .q(sclk_s));

  sef_uart_rx #(.DATA_BITS(DATA_BITS), .OS_RATE(OS_RATE), .SAMPLE_AT(SAMPLE_AT)) u_rx (
    .clk(clk), .rst_n(rst_ns), .enable(mode_uart), .os_tick(os_tick),
    .rxd_s(rxd_s), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .done(rx_done), .data(rx_word), .par_bad(rx_par_bad), .stop_bad(rx_stop_bad));

  assign halt = !mode_uart && clk_int && flags.pe_ur;

  sef_sio_tx #(.DATA_BITS(DATA_BITS)) u_tx (
    .clk(clk), .rst_n(rst_ns), .enable(!mode_uart), .clk_int(clk_int),
    .dbuf_en(dbuf_en), .halt(halt), .shift_tick(shift_tick), .sclk_s(sclk_s),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .txd(txd), .sclk_out(sclk_out),
    .underrun(tx_unr));

  always_comb begin
    rxd_d   = rxd_q;
    full_d  = full_q;
    evt.ovr = 1'b0;
    if (rx_done) begin
      if (full_q && !rx_rd) begin
        evt.ovr = 1'b1;
      end else begin
        rxd_d  = rx_word;
        full_d = 1'b1;
      end
    end else if (rx_rd) begin
      full_d = 1'b0;
    end
    evt.pe_ur = mode_uart ? (rx_done && rx_par_bad) : tx_unr;
    evt.frame = rx_done && rx_stop_bad;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rxd_q  <= '0;
      full_q <= 1'b0;
    end else begin
      rxd_q  <= rxd_d;
      full_q <= full_d;
    end
  end

  sef_flags u_flags (
    .clk(clk), .rst_n(rst_ns), .set(evt), .rd_clr(stat_rd),
    .frame_hold(!mode_uart), .flags(flags));

  assign rx_data    = rxd_q;
  assign pe_ur_flag = flags.pe_ur;
  assign frame_flag = flags.frame;
  assign ovr_flag   = flags.ovr;
endmodule

// File: rtl/sef_err_unit_chk.sv
module sef_err_unit_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_uart,
  input logic                 clk_int,
  input logic                 par_en,
  input logic                 stat_rd,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 sclk_out,
  input logic                 pe_ur_flag,
  input logic                 frame_flag,
  input logic                 ovr_flag
);
  p_frame_low_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_uart |=> !frame_flag);

  p_peur_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_ur_flag && !stat_rd) |=> pe_ur_flag);

  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !stat_rd) |=> ovr_flag);

  p_frame_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_flag && !stat_rd && mode_uart) |=> frame_flag);

  p_clk_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_uart && clk_int && pe_ur_flag) |=> sclk_out);

  p_sclk_idle_uart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_uart |-> sclk_out);

  p_ovr_keeps_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $stable(rx_data));

  p_no_parity_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_uart && !par_en && !pe_ur_flag) |=> !pe_ur_flag);
endmodule

bind sef_err_unit sef_err_unit_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_uart(mode_uart), .clk_int(clk_int),
  .par_en(par_en), .stat_rd(stat_rd), .rx_data(rx_data), .sclk_out(sclk_out),
  .pe_ur_flag(pe_ur_flag), .frame_flag(frame_flag), .ovr_flag(ovr_flag));

// File: tb/sef_err_unit_tb.sv
module sef_err_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n, mode_uart, clk_int, dbuf_en, par_en, par_odd, two_stop;
  logic       os_tick, rxd, rx_rd, stat_rd, shift_tick, sclk_in, tx_wr;
  logic [7:0] tx_wdata, rx_data;
  logic       txd, sclk_out, pe_ur_flag, frame_flag, ovr_flag;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  sef_err_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode_uart(mode_uart), .clk_int(clk_int),
    .dbuf_en(dbuf_en), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .os_tick(os_tick), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
    .stat_rd(stat_rd), .shift_tick(shift_tick), .sclk_in(sclk_in),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .txd(txd), .sclk_out(sclk_out),
    .pe_ur_flag(pe_ur_flag), .frame_flag(frame_flag), .ovr_flag(ovr_flag));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit r_rx, input bit r_st);
    rx_rd = r_rx; stat_rd = r_st;
    @(negedge clk);
    rx_rd = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    rxd = b;
    idle(16);
  endtask

  // bad_stop: 0 none, 1 first stop bit low, 2 second stop bit low
  task automatic send_frame(input logic [7:0] d, input bit inj, input int bad_stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (par_en) send_bit((^d) ^ par_odd ^ inj);
    send_bit(bad_stop == 1 ? 1'b0 : 1'b1);
    if (two_stop) send_bit(bad_stop == 2 ? 1'b0 : 1'b1);
    rxd = 1'b1;
    idle(40);
  endtask

  task automatic tx_write(input logic [7:0] d);
    tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic ext_edge(output bit b);
    b = txd;
    sclk_in = 1'b1;
    idle(4);
    sclk_in = 1'b0;
    idle(4);
  endtask

  task automatic ext_byte(output logic [7:0] v);
    bit b;
    for (int i = 0; i < 8; i++) begin
      ext_edge(b);
      v[i] = b;
    end
  endtask

  task automatic int_run(input int n, output int rises, output logic [15:0] bits);
    logic prev;
    int   nb;
    rises = 0; nb = 0; bits = '0; prev = sclk_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sclk_out == 1'b0 && nb < 16) begin
        bits[nb] = txd;
        nb++;
      end
      if (!prev && sclk_out) rises++;
      prev = sclk_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d, v, w;
    logic [15:0] bits;
    int          rises;
    bit          b;
    rst_n = 1'b0; mode_uart = 1'b1; clk_int = 1'b0; dbuf_en = 1'b1;
    par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0; os_tick = 1'b1;
    rxd = 1'b1; rx_rd = 1'b0; stat_rd = 1'b0; shift_tick = 1'b1;
    sclk_in = 1'b0; tx_wr = 1'b0; tx_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R13 reset state
    check("R13 pe_ur_flag", pe_ur_flag, 0);
    check("R13 frame_flag", frame_flag, 0);
    check("R13 ovr_flag", ovr_flag, 0);
    check("R13 rx_data", rx_data, 0);
    check("R13 txd", txd, 1);
    check("R13 sclk_out", sclk_out, 1);

    // R1 R2 R3 R4 R12 sweep over parity mode, injected fault, stop config
    for (int pe = 0; pe < 3; pe++)
      for (int inj = 0; inj < 2; inj++)
        for (int ts = 0; ts < 2; ts++)
          for (int bs = 0; bs < (ts ? 3 : 2); bs++)
            for (int k = 0; k < 4; k++) begin
              par_en = (pe != 0); par_odd = (pe == 2); two_stop = ts[0];
              d = 8'(k * 73 + pe * 29 + bs * 11 + inj * 5 + 8'h35);
              idle(2);
              send_frame(d, inj[0], bs);
              check(pe == 0 ? "R2 parity off flag" : "R1 parity flag",
                    pe_ur_flag, (pe != 0 && inj != 0) ? 1 : 0);
              check(bs == 2 ? "R4 second stop ignored" : "R3 framing flag",
                    frame_flag, bs == 1 ? 1 : 0);
              check("R12 rx_data", rx_data, d);
              check("R6 no overrun when read", ovr_flag, 0);
              strobe(1'b1, 1'b1);
              check("R11 pe_ur cleared by read", pe_ur_flag, 0);
              check("R11 frame cleared by read", frame_flag, 0);
            end

    // R6 overrun keeps old byte
    par_en = 1'b0; two_stop = 1'b0;
    send_frame(8'hA5, 1'b0, 0);
    send_frame(8'h3C, 1'b0, 0);
    check("R6 overrun flag", ovr_flag, 1);
    check("R6 old byte kept", rx_data, 8'hA5);
    strobe(1'b1, 1'b0);
    send_frame(8'h77, 1'b0, 0);
    check("R6 new byte after read", rx_data, 8'h77);
    check("R11 overrun sticky", ovr_flag, 1);
    strobe(1'b1, 1'b1);
    check("R11 overrun cleared", ovr_flag, 0);

    // R5 framing flag forced low in sync mode
    send_frame(8'h12, 1'b0, 1);
    check("R5 frame set in uart", frame_flag, 1);
    mode_uart = 1'b0;
    idle(2);
    check("R5 frame low in sync", frame_flag, 0);

    // R7 R12 external clock, double buffered
    clk_int = 1'b0; dbuf_en = 1'b1;
    idle(4);
    tx_write(8'hC6);
    idle(4);
    ext_byte(v);
    check("R12 tx byte ext", v, 8'hC6);
    check("R7 no under-run while data sent", pe_ur_flag, 0);
    ext_edge(b);
    check("R7 under-run on idle edge", pe_ur_flag, 1);
    check("R5 frame stays low", frame_flag, 0);
    strobe(1'b0, 1'b1);
    check("R11 under-run cleared", pe_ur_flag, 0);

    // R7 back-to-back buffered bytes
    tx_write(8'h81);
    idle(2);
    tx_write(8'h5E);
    idle(2);
    ext_byte(v);
    ext_byte(w);
    check("R12 first buffered byte", v, 8'h81);
    check("R12 second buffered byte", w, 8'h5E);
    check("R7 no under-run after last byte", pe_ur_flag, 0);
    ext_edge(b);
    check("R7 under-run after buffer empty", pe_ur_flag, 1);
    strobe(1'b0, 1'b1);

    // R11 error event in the same cycle as a read keeps the flag
    sclk_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R11 set wins over read", pe_ur_flag, 1);
    sclk_in = 1'b0;
    idle(4);
    strobe(1'b0, 1'b1);
    check("R11 later read clears", pe_ur_flag, 0);

    // R8 no under-run without double buffering
    dbuf_en = 1'b0;
    tx_write(8'h4B);
    idle(4);
    ext_byte(v);
    check("R12 tx byte single buffer", v, 8'h4B);
    ext_edge(b);
    ext_edge(b);
    check("R8 no under-run ext", pe_ur_flag, 0);

    // R9 internal clock
    clk_int = 1'b1; dbuf_en = 1'b1;
    idle(2);
    tx_write(8'hD3);
    int_run(60, rises, bits);
    check("R9 rising edges per byte", rises, 8);
    check("R12 tx byte int", bits[7:0], 8'hD3);
    check("R9 under-run int", pe_ur_flag, 1);
    check("R9 clock idles high", sclk_out, 1);

    // R10 clock held while flag set
    tx_write(8'h2A);
    int_run(40, rises, bits);
    check("R10 no edges while flagged", rises, 0);
    check("R10 sclk held high", sclk_out, 1);
    strobe(1'b0, 1'b1);
    int_run(60, rises, bits);
    check("R10 resumes after read", rises, 8);
    check("R12 resumed byte", bits[7:0], 8'h2A);
    check("R9 under-run again", pe_ur_flag, 1);
    strobe(1'b0, 1'b1);

    // R9 two bytes back to back
    tx_write(8'h0F);
    tx_write(8'hB4);
    int_run(80, rises, bits);
    check("R9 sixteen edges", rises, 16);
    check("R12 two bytes int", bits, 16'hB40F);
    check("R9 flag after both", pe_ur_flag, 1);
    strobe(1'b0, 1'b1);

    // R8 internal clock without double buffering
    dbuf_en = 1'b0;
    tx_write(8'h69);
    int_run(60, rises, bits);
    check("R9 edges single buffer", rises, 8);
    check("R8 no under-run int", pe_ur_flag, 0);

    // R9 no clock in uart mode
    mode_uart = 1'b1;
    idle(2);
    check("R9 sclk high in uart", sclk_out, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule